// File: doc/BRIEF.md
# Daisy-Chain Converter Serial Port

This block is the digital serial port of one 18-bit sampling converter that is meant to be wired in a daisy chain on a three-wire bus. The bus has a convert-start line, a serial clock and a serial line per device. Each device's serial input comes from the serial output of the device before it. The first device's serial input is tied to the convert-start line. All inputs are sampled on the system clock `clk`, and edges on them are found by comparing each input with its value one cycle earlier. A behavioural converter stub supplies an 18-bit result and a one-cycle done strobe.

A rising edge on the convert-start line while the serial clock is high starts a chain-mode conversion. The convert-start line then stays high through the conversion and the readback. When the done strobe arrives, the result is loaded in parallel into an 18-bit shift register, and the output line follows the upstream serial input. A high level therefore ripples toward the host once every device upstream has finished, and the host uses that rising level as its busy flag. The first serial-clock falling edge after that puts the result's MSB on the line. Each further falling edge shifts the register by one bit, taking the upstream bit in at the LSB, so the data of devices further up the chain follows this device's own data. A falling edge on the convert-start line ends the readback from any state.

The control FSM has five states:
- `ST_IDLE`: the output is low.
- `ST_NOCHAIN`: entered on a start edge while the serial clock is low. The output stays low until start falls.
- `ST_CONVERT`: entered on a start edge while the serial clock is high. The FSM leaves on the done strobe (load) to `ST_FLAG`.
- `ST_FLAG`: the output follows the serial input. The FSM leaves on the first serial-clock fall to `ST_SHIFT`, without shifting.
- `ST_SHIFT`: the output is the register MSB, and the register shifts on each serial-clock fall.

From every state except `ST_IDLE`, a falling start edge returns the FSM to `ST_IDLE` and clears the register.

Top module: `chain_adc_port`

## Requirements
- R1: After reset the serial output is 0.
- R2: A start rising edge while `sclk_i` is 1 begins a chain conversion. During that conversion the serial output is 0 whatever the serial input does.
- R3: A start rising edge while `sclk_i` is 0 does not enter chain mode. The serial output stays 0 through done strobes, serial input highs and clock toggles until start falls.
- R4: After the done strobe of a chain conversion, the serial output equals the current serial input level (the busy flag that ripples through the chain).
- R5: On falling serial-clock edge k (k = 1..18) after the flag, the serial output becomes bit 18-k of the loaded result (MSB first).
- R6: Each falling edge from the 2nd onward captures the serial input level into the register LSB. A bit captured on edge k appears on the output after edge k+17.
- R7: A start falling edge ends any conversion or readback. The output is then 0, and serial-clock edges while start is low produce no data.
- R8: A done strobe outside a chain conversion is ignored: it raises no flag and loads no data.
- R9: Whenever start and the serial input are both 0, the serial output is 0 in the same cycle, even before the FSM has reacted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Convert-start line; held high through conversion and readback |
| sclk_i | input | 1 | Serial clock; its level at the start edge selects the mode, and its falling edge shifts |
| ser_in_i | input | 1 | Serial input from the upstream device (or the start line for the first device) |
| conv_done_i | input | 1 | One-cycle strobe from the converter stub: result is valid |
| conv_word_i | input | 18 | Conversion result |
| ser_out_o | output | 1 | Serial output: busy flag, then data MSB first, then the upstream data |

## Verification
Readouts are run with walking-one results paired with their complements as upstream data, with all-zero, all-one and alternating words, and with pseudo-random pairs. Together these show any bit that is misplaced, stuck or taken from the wrong source, and whether the own-data to upstream-data boundary falls on the right edge. The flag is checked with both serial-input levels to separate real pass-through from a fixed high. Start edges with the serial clock low, done strobes while idle, and readbacks aborted mid-stream with the serial input high test the mode choice and the quiet cases.

// File: rtl/chain_port_pkg.sv
package chain_port_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_NOCHAIN = 3'd1,
        ST_CONVERT = 3'd2,
        ST_FLAG    = 3'd3,
        ST_SHIFT   = 3'd4
    } port_state_t;
endpackage

// File: rtl/chain_port_edges.sv
module chain_port_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic sclk_i,
    output logic start_rise,
    output logic start_fall,
    output logic sclk_fall
);
    logic start_q;
    logic sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            sclk_q  <= 1'b0;
        end else begin
            start_q <= start_i;
            sclk_q  <= sclk_i;
        end
    end

    assign start_rise = start_i & ~start_q;
    assign start_fall = ~start_i & start_q;
    assign sclk_fall  = ~sclk_i & sclk_q;
endmodule

// File: rtl/chain_port_shifter.sv
module chain_port_shifter #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic             msb
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (clear) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= load_val;
        end else if (shift_en) begin
            sreg <= {sreg[TOP-1:0], ser_in};
        end
    end

    assign msb = sreg[TOP];

    AST_LOAD_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> sreg == $past(load_val));  // R5

    AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load && !clear) |=> (sreg[TOP:1] == $past(sreg[TOP-1:0]) && sreg[0] == $past(ser_in)));  // R6
endmodule

// File: rtl/chain_port_fsm.sv
module chain_port_fsm
    import chain_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic sclk_i,
    input  logic ser_in_i,
    input  logic start_rise,
    input  logic start_fall,
    input  logic sclk_fall,
    input  logic conv_done_i,
    input  logic data_msb,
    output logic clear,
    output logic load,
    output logic shift_en,
    output logic ser_out
);
    port_state_t state;
    port_state_t state_nx;
    logic        raw_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        clear    = 1'b0;
        load     = 1'b0;
        shift_en = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_rise) begin
                    clear    = 1'b1;
                    state_nx = sclk_i ? ST_CONVERT : ST_NOCHAIN;
                end
            end
            ST_NOCHAIN: begin
                if (start_fall) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_CONVERT: begin
                if (start_fall) begin
                    clear    = 1'b1;
                    state_nx = ST_IDLE;
                end else if (conv_done_i) begin
                    load     = 1'b1;
                    state_nx = ST_FLAG;
                end
            end
            ST_FLAG: begin
                if (start_fall) begin
                    clear    = 1'b1;
                    state_nx = ST_IDLE;
                end else if (sclk_fall) begin
                    state_nx = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (start_fall) begin
                    clear    = 1'b1;
                    state_nx = ST_IDLE;
                end else if (sclk_fall) begin
                    shift_en = 1'b1;
                end
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        unique case (state)
            ST_FLAG:  raw_out = ser_in_i;
            ST_SHIFT: raw_out = data_msb;
            default:  raw_out = 1'b0;
        endcase
        ser_out = raw_out & (start_i | ser_in_i);
    end

    AST_CHAIN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_rise && sclk_i) |=> state == ST_CONVERT);  // R2

    AST_NOCHAIN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_rise && !sclk_i) |=> state == ST_NOCHAIN);  // R3

    AST_DONE_TO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONVERT && conv_done_i && !start_fall) |=> state == ST_FLAG);  // R4

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start_fall) |=> state == ST_IDLE);  // R7

    AST_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && conv_done_i && !start_rise) |=> state == ST_IDLE);  // R8
endmodule

// File: rtl/chain_adc_port.sv
module chain_adc_port #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             sclk_i,
    input  logic             ser_in_i,
    input  logic             conv_done_i,
    input  logic [WIDTH-1:0] conv_word_i,
    output logic             ser_out_o
);
    logic start_rise;
    logic start_fall;
    logic sclk_fall;
    logic clear;
    logic load;
    logic shift_en;
    logic data_msb;

    chain_port_edges u_edges (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .sclk_i     (sclk_i),
        .start_rise (start_rise),
        .start_fall (start_fall),
        .sclk_fall  (sclk_fall)
    );

    chain_port_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .sclk_i      (sclk_i),
        .ser_in_i    (ser_in_i),
        .start_rise  (start_rise),
        .start_fall  (start_fall),
        .sclk_fall   (sclk_fall),
        .conv_done_i (conv_done_i),
        .data_msb    (data_msb),
        .clear       (clear),
        .load        (load),
        .shift_en    (shift_en),
        .ser_out     (ser_out_o)
    );

    chain_port_shifter #(.WIDTH(WIDTH)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .load     (load),
        .load_val (conv_word_i),
        .shift_en (shift_en),
        .ser_in   (ser_in_i),
        .msb      (data_msb)
    );

    AST_LOAD_OR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift_en));  // R6
endmodule

// File: tb/sim_chain_adc_port.sv
module sim_chain_adc_port;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         sclk_i = 1'b1;
    logic         ser_in_i = 1'b0;
    logic         conv_done_i = 1'b0;
    logic [W-1:0] conv_word_i = '0;
    logic         ser_out_o;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    chain_adc_port #(.WIDTH(W)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .sclk_i      (sclk_i),
        .ser_in_i    (ser_in_i),
        .conv_done_i (conv_done_i),
        .conv_word_i (conv_word_i),
        .ser_out_o   (ser_out_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: ser_out=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic begin_chain();
        start_i  = 1'b0;
        sclk_i   = 1'b1;
        ser_in_i = 1'b0;
        tick();
        start_i  = 1'b1;
        ser_in_i = 1'b1;
        tick();
        chk("R2", ser_out_o, 1'b0);
        tick();
        chk("R2", ser_out_o, 1'b0);
    endtask

    task automatic finish_conv(input logic [W-1:0] w);
        conv_done_i = 1'b1;
        conv_word_i = w;
        tick();
        conv_done_i = 1'b0;
        ser_in_i = 1'b1;
        #1 chk("R4", ser_out_o, 1'b1);
        ser_in_i = 1'b0;
        #1 chk("R4", ser_out_o, 1'b0);
        ser_in_i = 1'b1;
    endtask

    task automatic run_chain(input logic [W-1:0] w, input logic [W-1:0] up);
        begin_chain();
        finish_conv(w);
        for (int k = 1; k <= 2 * W; k++) begin
            if (k == 1) ser_in_i = 1'b1;
            else if (k <= W + 1) ser_in_i = up[W + 1 - k];
            else ser_in_i = 1'b0;
            sclk_i = 1'b0;
            tick();
            if (k <= W) chk("R5", ser_out_o, w[W - k]);
            else chk("R6", ser_out_o, up[2 * W - k]);
            sclk_i = 1'b1;
            tick();
        end
        start_i  = 1'b0;
        ser_in_i = 1'b0;
        #1 chk("R9", ser_out_o, 1'b0);
        tick();
        chk("R7", ser_out_o, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        logic [W-1:0] wv;
        logic [W-1:0] uv;
        repeat (3) tick();
        chk("R1", ser_out_o, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R1", ser_out_o, 1'b0);

        // R8: done strobe while idle is ignored, then a chain conversion shows no early flag
        ser_in_i = 1'b1;
        conv_done_i = 1'b1;
        conv_word_i = '1;
        tick();
        conv_done_i = 1'b0;
        chk("R8", ser_out_o, 1'b0);
        begin_chain();
        chk("R8", ser_out_o, 1'b0);
        start_i = 1'b0;
        tick();

        // R3: start edge with serial clock low
        sclk_i = 1'b0;
        tick();
        start_i = 1'b1;
        ser_in_i = 1'b1;
        tick();
        chk("R3", ser_out_o, 1'b0);
        conv_done_i = 1'b1;
        conv_word_i = '1;
        tick();
        conv_done_i = 1'b0;
        chk("R3", ser_out_o, 1'b0);
        for (int i = 0; i < 6; i++) begin
            sclk_i = ~sclk_i;
            tick();
            chk("R3", ser_out_o, 1'b0);
        end
        start_i = 1'b0;
        ser_in_i = 1'b0;
        tick();

        // R7: abort mid-readback, then clock with start low
        begin_chain();
        finish_conv(18'h3FFFF);
        for (int k = 0; k < 5; k++) begin
            sclk_i = 1'b0;
            tick();
            sclk_i = 1'b1;
            tick();
        end
        start_i = 1'b0;
        ser_in_i = 1'b1;
        tick();
        chk("R7", ser_out_o, 1'b0);
        for (int k = 0; k < 4; k++) begin
            sclk_i = ~sclk_i;
            tick();
            chk("R7", ser_out_o, 1'b0);
        end
        sclk_i = 1'b1;
        ser_in_i = 1'b0;
        tick();

        // sweeps
        run_chain('0, '1);
        run_chain('1, '0);
        run_chain(18'h2AAAA, 18'h15555);
        run_chain(18'h15555, 18'h2AAAA);
        for (int i = 0; i < W; i++) begin
            wv = 18'(1) << i;
            run_chain(wv, ~wv);
        end
        lcg = 32'h1234_5678;
        for (int i = 0; i < 8; i++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            wv = lcg[29:12];
            lcg = lcg * 32'd1103515245 + 32'd12345;
            uv = lcg[29:12];
            run_chain(wv, uv);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule